// File: doc/BRIEF.md
# Three-Mode Power Controller

This block sets the chip's power state and drives the enables that follow from it. In the normal running mode every clock is on. In the idle mode only the processor clock is stopped. The peripheral domain keeps its clock, so the timers, the interrupt logic and the general-purpose pins go on working. In the sleep mode both clock enables drop, the processor is held in reset, and the supply-enable output goes low so that the external regulators can switch off. The controller itself keeps running on a slow clock so that it can see wake events.

Software asks for idle with a one-cycle request. It asks for sleep by setting a sleep flag. A supply-fault input forces sleep in hardware. Any interrupt line wakes the block from idle straight into run. A wake from sleep first raises the supply enable, then waits a fixed settle count while the processor stays in reset, and only then returns to run. A status field keeps the cause of the last wake and the lowest-numbered interrupt line behind it.

Top module: `pm_power_ctrl`

## Requirements
- R1: After reset the mode is run (code 0), the wake cause is 0 (reset), the sleep flag is 0, and all four enable outputs are 1.
- R2: An `idle_req` pulse in run moves the mode to idle (code 1) at the next clock edge. In idle, `cpu_clk_en` is 0 and `periph_clk_en`, `pwr_en` and `cpu_rst_n` are 1.
- R3: In idle, when no fault is present and the sleep flag is clear, any set bit of `wake_irq` returns the mode to run at the next edge. That edge sets `wake_cause` to 1 and `wake_src` to the lowest set bit index.
- R4: A `sleep_set` pulse in run or idle sets `sleep_flag` at the next edge. At the edge after that the mode becomes sleep (code 2) and the flag clears itself.
- R5: When `supply_fault` is high in run, idle or settle, the mode becomes sleep at the next edge.
- R6: In sleep, `pwr_en`, `cpu_rst_n`, `cpu_clk_en` and `periph_clk_en` are all 0.
- R7: In sleep, while `supply_fault` is high, the mode stays sleep whatever `wake_irq` does.
- R8: In sleep with no fault, a set bit of `wake_irq` moves the mode to settle (code 3). That edge sets `wake_cause` to 2 and `wake_src` to the lowest set index. In settle, `pwr_en` is 1 and the other three enables are 0. The mode stays in settle for exactly `SETTLE_CYC` cycles and then goes to run.
- R9: `idle_req` has an effect only in run. `sleep_set` has an effect only in run and idle. In the other modes, neither input changes the mode or the sleep flag.
- R10: In run and idle, a fault or a set sleep flag wins over `idle_req` and over interrupts.
- R11: `wake_cause` changes only on a wake, with codes 0 = reset, 1 = interrupt from idle, 2 = interrupt from sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_req | input | 1 | Software request for idle, one-cycle pulse |
| sleep_set | input | 1 | Sets the sleep flag |
| supply_fault | input | 1 | Supply fault, forces sleep |
| wake_irq | input | N_IRQ | Interrupt lines that wake the block |
| mode | output | 2 | Mode code: 0 run, 1 idle, 2 sleep, 3 settle |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pwr_en | output | 1 | External supply enable |
| cpu_rst_n | output | 1 | Active-low processor reset |
| sleep_flag | output | 1 | Sleep flag, cleared on entry to sleep |
| wake_cause | output | 2 | Cause of the last wake |
| wake_src | output | $clog2(N_IRQ) | Lowest interrupt index at the last wake |

## Verification
A directed pass walks each entry and exit path once, with patterns chosen to separate competing causes. Two interrupt bits are raised together to tell the lowest-index pick apart from the highest. A fault is held together with an interrupt to show that the fault wins. A fault lands mid-settle to tell an abort from a completed count. Requests made in the wrong mode show that they are ignored. A long phase of random requests, faults and interrupt bursts follows, with every output compared each cycle against a behavioural model. This phase reaches collisions such as a sleep request meeting a wake, or a fault in the same cycle as an idle request.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_SLEEP  = 2'd2,
    PM_SETTLE = 2'd3
  } pm_mode_e;

  localparam logic [1:0] CAUSE_RESET = 2'd0;
  localparam logic [1:0] CAUSE_IDLE  = 2'd1;
  localparam logic [1:0] CAUSE_SLEEP = 2'd2;

  // enables per mode, packed as {cpu_clk, periph_clk, pwr, cpu_rst_n}
  function automatic logic [3:0] drive_for(pm_mode_e m);
    case (m)
      PM_RUN:    return 4'b1111;
      PM_IDLE:   return 4'b0111;
      PM_SETTLE: return 4'b0010;
      default:   return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/pm_wake_detect.sv
module pm_wake_detect #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] irq,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  function automatic logic [IDX_W-1:0] lowest_set(logic [N_IRQ-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_IRQ - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign any = |irq;
  assign idx = lowest_set(irq);
endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
  parameter int SETTLE_CYC = 8,
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + 1'b1;
  end

  assign done = active && (cnt_q == CNT_W'(SETTLE_CYC - 1));
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_pkg::*;
#(
  parameter int N_IRQ = 8,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             sleep_set,
  input  logic             fault,
  input  logic             any_irq,
  input  logic [IDX_W-1:0] irq_idx,
  input  logic             settle_done,
  output pm_mode_e         mode,
  output logic             sleep_flag,
  output logic [1:0]       wake_cause,
  output logic [IDX_W-1:0] wake_src,
  output logic             go_sleep,
  output logic             settle_start
);
  pm_mode_e st_q, st_d;
  logic flag_q, idle_wake;

  always_comb begin
    st_d = st_q;
    go_sleep = 1'b0;
    settle_start = 1'b0;
    idle_wake = 1'b0;
    case (st_q)
      PM_RUN:
        if (fault || flag_q) begin st_d = PM_SLEEP; go_sleep = 1'b1; end
        else if (idle_req) st_d = PM_IDLE;
      PM_IDLE:
        if (fault || flag_q) begin st_d = PM_SLEEP; go_sleep = 1'b1; end
        else if (any_irq) begin st_d = PM_RUN; idle_wake = 1'b1; end
      PM_SLEEP:
        if (!fault && any_irq) begin st_d = PM_SETTLE; settle_start = 1'b1; end
      PM_SETTLE:
        if (fault) begin st_d = PM_SLEEP; go_sleep = 1'b1; end
        else if (settle_done) st_d = PM_RUN;
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PM_RUN;
      flag_q     <= 1'b0;
      wake_cause <= CAUSE_RESET;
      wake_src   <= '0;
    end else begin
      st_q <= st_d;
      if (go_sleep)
        flag_q <= 1'b0;
      else if (sleep_set && (st_q == PM_RUN || st_q == PM_IDLE))
        flag_q <= 1'b1;
      if (idle_wake) begin
        wake_cause <= CAUSE_IDLE;
        wake_src   <= irq_idx;
      end else if (settle_start) begin
        wake_cause <= CAUSE_SLEEP;
        wake_src   <= irq_idx;
      end
    end
  end

  assign mode = st_q;
  assign sleep_flag = flag_q;
endmodule

// File: rtl/pm_power_ctrl.sv
module pm_power_ctrl
  import pm_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int SETTLE_CYC = 8,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             sleep_set,
  input  logic             supply_fault,
  input  logic [N_IRQ-1:0] wake_irq,
  output logic [1:0]       mode,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             pwr_en,
  output logic             cpu_rst_n,
  output logic             sleep_flag,
  output logic [1:0]       wake_cause,
  output logic [IDX_W-1:0] wake_src
);
  logic any_irq, settle_done, go_sleep, settle_start;
  logic [IDX_W-1:0] irq_idx;
  pm_mode_e mode_e;

  pm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq(wake_irq), .any(any_irq), .idx(irq_idx)
  );

  pm_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(settle_start),
    .active(mode_e == PM_SETTLE), .done(settle_done)
  );

  pm_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .sleep_set(sleep_set),
    .fault(supply_fault), .any_irq(any_irq), .irq_idx(irq_idx),
    .settle_done(settle_done), .mode(mode_e), .sleep_flag(sleep_flag),
    .wake_cause(wake_cause), .wake_src(wake_src), .go_sleep(go_sleep),
    .settle_start(settle_start)
  );

  assign mode = mode_e;
  assign {cpu_clk_en, periph_clk_en, pwr_en, cpu_rst_n} = drive_for(mode_e);
endmodule

// File: rtl/pm_power_ctrl_chk.sv
module pm_power_ctrl_chk
  import pm_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int SETTLE_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_req,
  input logic             sleep_set,
  input logic             supply_fault,
  input logic [N_IRQ-1:0] wake_irq,
  input logic [1:0]       mode,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             pwr_en,
  input logic             cpu_rst_n,
  input logic             sleep_flag,
  input logic [1:0]       wake_cause,
  input logic             go_sleep
);
  localparam int LW = $clog2(SETTLE_CYC + 1) + 1;
  logic [LW-1:0] settle_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                settle_len <= '0;
    else if (mode == PM_SETTLE) settle_len <= settle_len + 1'b1;
    else                       settle_len <= '0;
  end

  // R2
  idle_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN && idle_req && !supply_fault && !sleep_flag)
      |=> (mode == PM_IDLE && !cpu_clk_en && periph_clk_en && pwr_en && cpu_rst_n));

  // R3
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_IDLE && !supply_fault && !sleep_flag && (|wake_irq))
      |=> (mode == PM_RUN && wake_cause == CAUSE_IDLE));

  // R4
  flag_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_sleep |=> (mode == PM_SLEEP && !sleep_flag));

  // R5
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_fault && mode != PM_SLEEP) |=> mode == PM_SLEEP);

  // R6
  sleep_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP) |-> (!pwr_en && !cpu_rst_n && !cpu_clk_en && !periph_clk_en));

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP && supply_fault) |=> mode == PM_SLEEP);

  // R8
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SETTLE) |-> (settle_len < LW'(SETTLE_CYC) && pwr_en && !cpu_rst_n));

  // R8
  settle_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN && $past(mode) == PM_SETTLE) |-> settle_len == LW'(SETTLE_CYC));

  // R9
  sleep_set_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP && sleep_set) |=> !sleep_flag);

  // R11
  cause_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN) |=> $stable(wake_cause));
endmodule

bind pm_power_ctrl pm_power_ctrl_chk #(.N_IRQ(N_IRQ), .SETTLE_CYC(SETTLE_CYC)) u_chk (.*);

// File: tb/pm_power_ctrl_tb.sv
`timescale 1ns/1ps
module pm_power_ctrl_tb;
  localparam int N = 8;
  localparam int S = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic idle_req = 0, sleep_set = 0, supply_fault = 0;
  logic [N-1:0] wake_irq = '0;
  logic [1:0] mode, wake_cause;
  logic cpu_clk_en, periph_clk_en, pwr_en, cpu_rst_n, sleep_flag;
  logic [IW-1:0] wake_src;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;

  // model state: 0 run, 1 idle, 2 sleep, 3 settle
  int m_st = 0, m_cnt = 0, m_cause = 0, m_src = 0, m_flag = 0;

  always #10 clk = ~clk;

  pm_power_ctrl #(.N_IRQ(N), .SETTLE_CYC(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .sleep_set(sleep_set),
    .supply_fault(supply_fault), .wake_irq(wake_irq), .mode(mode),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .pwr_en(pwr_en),
    .cpu_rst_n(cpu_rst_n), .sleep_flag(sleep_flag), .wake_cause(wake_cause),
    .wake_src(wake_src)
  );

  function automatic int low_bit(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_cause = 0; m_src = 0; m_flag = 0;
    end else begin
      int ns, nf;
      bit into_sleep;
      ns = m_st; nf = m_flag; into_sleep = 0;
      if ((m_st == 0 || m_st == 1) && (supply_fault || m_flag != 0)) into_sleep = 1;
      else if (m_st == 3 && supply_fault) into_sleep = 1;
      if (into_sleep) ns = 2;
      else if (m_st == 0 && idle_req) ns = 1;
      else if (m_st == 1 && wake_irq != 0) begin
        ns = 0; m_cause = 1; m_src = low_bit(wake_irq);
      end else if (m_st == 2 && !supply_fault && wake_irq != 0) begin
        ns = 3; m_cnt = 0; m_cause = 2; m_src = low_bit(wake_irq);
      end else if (m_st == 3) begin
        m_cnt++;
        if (m_cnt == S) ns = 0;
      end
      if (into_sleep) nf = 0;
      else if (sleep_set && m_st <= 1) nf = 1;
      m_st = ns; m_flag = nf;
    end
  end

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(mode, m_st, "R10", "mode");
    chk(cpu_clk_en, m_st == 0, "R2", "cpu_clk_en");
    chk(periph_clk_en, m_st <= 1, "R2", "periph_clk_en");
    chk(pwr_en, m_st != 2, "R6", "pwr_en");
    chk(cpu_rst_n, m_st <= 1, "R8", "cpu_rst_n");
    chk(sleep_flag, m_flag, "R4", "sleep_flag");
    chk(wake_cause, m_cause, "R11", "wake_cause");
    chk(wake_src, m_src, "R3", "wake_src");
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    cmp_on = 1;
    // R1
    chk(mode, 0, "R1", "mode after reset");
    chk(wake_cause, 0, "R1", "cause after reset");
    chk(pwr_en & cpu_rst_n & cpu_clk_en & periph_clk_en, 1, "R1", "enables");
    // R2 idle entry
    idle_req = 1; tick(1); idle_req = 0;
    chk(mode, 1, "R2", "idle entry");
    chk(cpu_clk_en, 0, "R2", "cpu clock off in idle");
    // R3 wake from idle, two bits
    wake_irq = 8'b0010_0100; tick(1); wake_irq = '0;
    chk(mode, 0, "R3", "idle wake");
    chk(wake_src, 2, "R3", "lowest index");
    chk(wake_cause, 1, "R3", "cause idle");
    // R4 sleep via flag
    sleep_set = 1; tick(1); sleep_set = 0;
    chk(sleep_flag, 1, "R4", "flag set");
    tick(1);
    chk(mode, 2, "R4", "sleep entry");
    chk(sleep_flag, 0, "R4", "flag self clear");
    chk(pwr_en, 0, "R6", "power off");
    // R9 requests ignored in sleep
    sleep_set = 1; idle_req = 1; tick(1); sleep_set = 0; idle_req = 0;
    chk(sleep_flag, 0, "R9", "sleep_set ignored");
    chk(mode, 2, "R9", "idle_req ignored");
    // R7 fault beats wake
    supply_fault = 1; wake_irq = 8'h01; tick(2);
    chk(mode, 2, "R7", "fault holds sleep");
    // R8 settle
    supply_fault = 0; wake_irq = 8'h80; tick(1); wake_irq = '0;
    chk(mode, 3, "R8", "settle entry");
    chk(pwr_en, 1, "R8", "power on in settle");
    chk(cpu_rst_n, 0, "R8", "cpu reset held");
    chk(wake_cause, 2, "R8", "cause sleep");
    chk(wake_src, 7, "R8", "src");
    tick(S - 1);
    chk(mode, 3, "R8", "still settling");
    tick(1);
    chk(mode, 0, "R8", "run after settle");
    // R10 fault beats idle_req in run
    supply_fault = 1; idle_req = 1; tick(1); supply_fault = 0; idle_req = 0;
    chk(mode, 2, "R10", "fault over idle_req");
    // R5 fault during settle
    wake_irq = 8'h10; tick(1); wake_irq = '0; tick(2);
    supply_fault = 1; tick(1); supply_fault = 0;
    chk(mode, 2, "R5", "fault aborts settle");
    wake_irq = 8'h02; tick(1); wake_irq = '0; tick(S);
    // R5 fault in idle
    idle_req = 1; tick(1); idle_req = 0;
    supply_fault = 1; wake_irq = 8'h04; tick(1); supply_fault = 0; wake_irq = '0;
    chk(mode, 2, "R5", "fault from idle");
    // random phase
    for (int c = 0; c < 4000; c++) begin
      idle_req = ($urandom % 6) == 0;
      sleep_set = ($urandom % 20) == 0;
      if (($urandom % 30) == 0) supply_fault = ~supply_fault;
      wake_irq = (($urandom % 5) == 0) ? N'($urandom) : '0;
      tick(1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule